// File: doc/BRIEF.md
# CCK Modulo-4 Chip Encoder

This block turns one data byte into an eight-chip complementary code word of the kind used at the higher rates of 2.4 GHz wireless LAN physical layers. All phase arithmetic is done on 2-bit indices, where index n stands for a rotation of n·π/2. Sums and negations reduce to modulo-4 additions. A compact map then turns each chip phase into a pair of sign bits for the I and Q rails.

The byte is split into four dibits. The first dibit drives a differential phase, which is accumulated onto the value from the previous symbol. The other three dibits select absolute phases. A byte is taken over a valid/ready handshake. The eight chips then leave one at a time, lowest chip index first, each on a cycle in which the chip-rate strobe `chip_en` is high. The next byte is taken only after the eighth chip has gone out.

Top module: `cck_mod4_encoder`

## Requirements
- R1: After synchronous reset, `in_ready` is 1, `chip_valid` is 0 and the stored differential phase is index 0.
- R2: The byte is split into dibits as follows: A = {in_data[0], in_data[1]}, B = {in_data[2], in_data[3]}, C = {in_data[4], in_data[5]}, D = {in_data[6], in_data[7]}. The first-named bit is the MSB of each dibit.
- R3: Dibits B, C and D map straight to phase indices: 00→0, 01→1, 10→2, 11→3.
- R4: Dibit A is a phase step with 00→+0, 01→+1, 11→+2 and 10→+3. The step is added modulo 4 to the previous symbol's first phase, and the result becomes the new stored first phase.
- R5: With phases a, b, c, d, chips 0 to 7 have the indices a+b+c+d, a+c+d, a+b+d, a+d+2, a+b+c, a+c, a+b+2 and a, all taken modulo 4.
- R6: A chip index maps to (chip_i, chip_q) as 0→(1,1), 1→(0,1), 2→(0,0) and 3→(1,0). A bit value of 1 means +1 and 0 means −1.
- R7: While a symbol is in progress, `chip_valid` equals `chip_en` in the same cycle. Each such cycle presents the next chip, starting at chip 0. Cycles with `chip_en` low emit nothing and do not advance the chip sequence.
- R8: `in_ready` is low from the cycle after a byte is accepted until the cycle after the eighth chip. A byte offered in that window is neither taken nor allowed to change the differential phase.
- R9: While idle, `chip_en` produces no `chip_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Encoder can take a byte |
| chip_en | input | 1 | Chip-rate strobe |
| chip_valid | output | 1 | A chip is present on chip_i/chip_q |
| chip_i | output | 1 | In-phase sign bit (1 = +1) |
| chip_q | output | 1 | Quadrature sign bit (1 = +1) |

## Verification
A byte accepted at a clock edge puts chip 0 on `chip_i`/`chip_q` from that edge onward. Chip 0 counts as emitted in the first later cycle with `chip_en` high, because `chip_valid` follows `chip_en` combinationally with no added register. Each chip edge moves to the next chip. `in_ready` rises one edge after the eighth chip. The bench changes inputs just after a rising edge and samples at the falling edge of that same cycle. This way every chip, every idle gap and the return of `in_ready` is read in the exact cycle it is due, against a reference model that carries its own copy of the differential phase.

// File: rtl/cck_pkg.sv
package cck_pkg;
    localparam int PH_W   = 2;
    localparam int CHIPS  = 8;
    localparam int CNT_W  = $clog2(CHIPS);
    localparam int BYTE_W = 8;

    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [CNT_W-1:0] chip_idx_t;

    typedef struct packed {
        phase_t a;   // differential phase
        phase_t b;
        phase_t c;
        phase_t d;
    } phase_set_t;

    typedef struct packed {
        logic i;
        logic q;
    } iq_t;

    // absolute phase selection
    function automatic phase_t abs_phase(input logic [1:0] dib);
        return phase_t'(dib);
    endfunction

    // differential step: Gray order of rotation
    function automatic phase_t diff_step(input logic [1:0] dib);
        case (dib)
            2'b00:   return phase_t'(0);
            2'b01:   return phase_t'(1);
            2'b11:   return phase_t'(2);
            default: return phase_t'(3);
        endcase
    endfunction

    // phase of chip k: b on even chips, c where k[1]==0, d on the first half,
    // a negation (+2) on chips 3 and 6
    function automatic phase_t chip_phase(input phase_set_t s, input chip_idx_t k);
        phase_t sum;
        sum = s.a;
        if (!k[0]) sum = sum + s.b;
        if (!k[1]) sum = sum + s.c;
        if (!k[2]) sum = sum + s.d;
        if (k == chip_idx_t'(3) || k == chip_idx_t'(6)) sum = sum + phase_t'(2);
        return sum;
    endfunction

    function automatic iq_t phase_to_iq(input phase_t p);
        iq_t r;
        r.i = ~(p[1] ^ p[0]);
        r.q = ~p[1];
        return r;
    endfunction
endpackage

// File: rtl/cck_phase_gen.sv
module cck_phase_gen
    import cck_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] dat,
    output phase_set_t        ph
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
        end else if (load) begin
            ph.a <= ph.a + diff_step({dat[0], dat[1]});
            ph.b <= abs_phase({dat[2], dat[3]});
            ph.c <= abs_phase({dat[4], dat[5]});
            ph.d <= abs_phase({dat[6], dat[7]});
        end
    end

    // R8: phases (including the differential reference) move only on a load
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ph));
endmodule

// File: rtl/cck_chip_seq.sv
module cck_chip_seq
    import cck_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      chip_en,
    output logic      busy,
    output chip_idx_t cnt
);
    localparam chip_idx_t LAST = chip_idx_t'(CHIPS - 1);

    logic step;
    assign step = busy && chip_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (step) begin
            cnt <= cnt + chip_idx_t'(1);
            if (cnt == LAST) busy <= 1'b0;
        end
    end

    // R7: each emitted chip advances the sequence by one
    a_r7_chip_advance: assert property (@(posedge clk) disable iff (rst)
        (step && cnt != LAST) |=> (busy && cnt == $past(cnt) + chip_idx_t'(1)));
    // R7: without a strobe the sequence holds
    a_r7_chip_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !chip_en) |=> (busy && $stable(cnt)));
    // R8: the last chip releases the symbol
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        (step && cnt == LAST) |=> !busy);
endmodule

// File: rtl/cck_iq_out.sv
module cck_iq_out
    import cck_pkg::*;
(
    input  phase_set_t ph,
    input  chip_idx_t  cnt,
    input  logic       busy,
    input  logic       chip_en,
    output logic       chip_valid,
    output logic       chip_i,
    output logic       chip_q
);
    phase_t lane [CHIPS];

    for (genvar k = 0; k < CHIPS; k++) begin : g_lane
        assign lane[k] = chip_phase(ph, chip_idx_t'(k));
    end

    iq_t sel;
    always_comb begin
        sel        = phase_to_iq(lane[cnt]);
        chip_valid = busy && chip_en;
        chip_i     = sel.i;
        chip_q     = sel.q;
    end
endmodule

// File: rtl/cck_mod4_encoder.sv
module cck_mod4_encoder
    import cck_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    input  logic              chip_en,
    output logic              chip_valid,
    output logic              chip_i,
    output logic              chip_q
);
    logic       busy;
    logic       accept;
    chip_idx_t  cnt;
    phase_set_t ph;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    cck_phase_gen u_phase (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .dat  (in_data),
        .ph   (ph)
    );

    cck_chip_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .chip_en (chip_en),
        .busy    (busy),
        .cnt     (cnt)
    );

    cck_iq_out u_out (
        .ph         (ph),
        .cnt        (cnt),
        .busy       (busy),
        .chip_en    (chip_en),
        .chip_valid (chip_valid),
        .chip_i     (chip_i),
        .chip_q     (chip_q)
    );

    // R8: an accepted byte closes the input until its chips are out
    a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);
    // R9: chips only while a symbol is held
    a_r9_no_idle_chip: assert property (@(posedge clk) disable iff (rst)
        chip_valid |-> !in_ready);
endmodule

// File: tb/cck_mod4_encoder_tb.sv
`timescale 1ns/1ps
module cck_mod4_encoder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic       chip_en;
    logic       chip_valid;
    logic       chip_i;
    logic       chip_q;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;
    logic [1:0] ref_a;

    always #2.5 clk = ~clk;

    cck_mod4_encoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .chip_en(chip_en), .chip_valid(chip_valid),
        .chip_i(chip_i), .chip_q(chip_q)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_step(input logic [1:0] d);
        case (d)
            2'b00: return 2'd0;
            2'b01: return 2'd1;
            2'b11: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [1:0] ref_chip(input logic [1:0] a, b, c, d, input int k);
        logic [1:0] r;
        case (k)
            0: r = a + b + c + d;
            1: r = a + c + d;
            2: r = a + b + d;
            3: r = a + d + 2'd2;
            4: r = a + b + c;
            5: r = a + c;
            6: r = a + b + 2'd2;
            default: r = a;
        endcase
        return r;
    endfunction

    // R6 table
    function automatic logic [1:0] ref_iq(input logic [1:0] p);
        case (p)
            2'd0: return 2'b11;
            2'd1: return 2'b01;
            2'd2: return 2'b00;
            default: return 2'b10;
        endcase
    endfunction

    task automatic t_reset();
        rst = 1; in_valid = 0; in_data = 0; chip_en = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        ref_a = 2'd0;
        @(negedge clk);
        check("R1", in_ready, 1, "in_ready after reset");
        check("R1", chip_valid, 0, "chip_valid after reset");
    endtask

    // offers a byte, then drains 8 chips with 'gap' strobe-free cycles before each;
    // optionally offers 'other' while busy
    task automatic t_symbol(input logic [7:0] b, input int gap, input bit offer, input logic [7:0] other);
        logic [1:0] a, pb, pc, pd, ph, iq;
        @(negedge clk);
        check("R8", in_ready, 1, "ready before byte");
        in_valid = 1; in_data = b;
        @(posedge clk);
        #1;
        if (offer) in_data = other; else in_valid = 0;
        a  = ref_a + ref_step({b[0], b[1]});   // R4
        pb = {b[2], b[3]};                     // R2, R3
        pc = {b[4], b[5]};
        pd = {b[6], b[7]};
        ref_a = a;
        for (int k = 0; k < 8; k++) begin
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                check("R7", chip_valid, 0, "no chip without strobe");
                check("R8", in_ready, 0, "ready low in gap");
                @(posedge clk);
                #1;
            end
            if (offer && k == 7) in_valid = 0;
            chip_en = 1;
            @(negedge clk);
            ph = ref_chip(a, pb, pc, pd, k);
            iq = ref_iq(ph);
            check("R7", chip_valid, 1, $sformatf("chip_valid byte %02h chip %0d", b, k));
            check("R8", in_ready, 0, "ready low during symbol");
            check("R5", chip_i, iq[1], $sformatf("R6 chip_i byte %02h chip %0d", b, k));
            check("R5", chip_q, iq[0], $sformatf("R6 chip_q byte %02h chip %0d", b, k));
            @(posedge clk);
            #1 chip_en = 0;
        end
        @(negedge clk);
        check("R8", in_ready, 1, "ready after eighth chip");
        check("R7", chip_valid, 0, "no chip after symbol");
    endtask

    task automatic t_idle_strobe();
        @(posedge clk);
        #1 chip_en = 1;
        repeat (3) begin
            @(negedge clk);
            check("R9", chip_valid, 0, "strobe while idle");
            check("R9", in_ready, 1, "idle stays ready");
        end
        @(posedge clk);
        #1 chip_en = 0;
    endtask

    initial begin
        t_reset();
        t_symbol(8'h00, 0, 0, 8'h00);
        t_symbol(8'hFF, 1, 0, 8'h00);
        t_symbol(8'h1B, 0, 0, 8'h00);
        t_symbol(8'hE4, 2, 0, 8'h00);
        t_idle_strobe();
        // R8: a byte held during the symbol must not be taken or shift the phase
        t_symbol(8'h5A, 0, 1, 8'hC3);
        t_symbol(8'h96, 0, 0, 8'h00);
        for (int i = 0; i < 16; i++) t_symbol(8'(i * 37 + 5), i % 3, 0, 8'h00);
        // R1: reset clears the differential reference
        t_reset();
        t_symbol(8'h02, 0, 0, 8'h00);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule